// File: doc/BRIEF.md
# Interleaved Forward State-Metric Recursion

This block computes forward state metrics for a four-state log-MAP trellis (rate 1/2 code with two memory elements). The trellis is shared in time by `NSUB` independent sub-blocks of one code block. Each clock cycle belongs to one sub-block, taken in strict rotation 0, 1, ..., `NSUB`-1, 0, and so on. On each cycle the caller may present one trellis section's branch metrics for the sub-block that owns that cycle. The recursion loop holds exactly `NSUB` register stages. A sub-block's updated metrics therefore come back to the loop input just in time for that sub-block's next cycle. This lets the add-compare-select path be split over two of those stages without losing throughput.

A sub-block begins with a start flag. The first sub-block of a block starts from the known zero state. Every other sub-block starts from equal metrics and first runs warm-up sections taken from the end of the sub-block before it. Warm-up sections update the metrics but produce no valid output. Branch metric generation, the backward recursion, LLR computation and interleaver memories are handled by neighbouring blocks.

Top module: `bip_acs_fwd`

## Requirements
- R1: State s is written as bits {s[1], s[0]}. Next state n has two predecessors, p = {n[0], 0} and p = {n[0], 1}, and the input bit on both branches is u = n[1]. The branch from p carries codeword c = {u^p[1]^p[0], u^p[0]}. Its branch metric is the unsigned `BMW`-bit lane c of `in_bm`, found at bits [BMW*c+BMW-1 : BMW*c]. The candidate value is the predecessor's metric plus that lane.
- R2: Each new metric is the larger of its two candidates plus a correction. The correction comes from a table indexed by the absolute candidate difference, saturated to 7. For indices 0 to 7 the table gives 5, 4, 3, 2, 2, 1, 1, 0.
- R3: After correction, the value of state 0 is subtracted from all four states. Each result is then saturated to the signed `SMW`-bit range. The output metric of state n is two's complement at `out_metric[SMW*n+SMW-1 : SMW*n]`.
- R4: A valid section with `in_start`=1 and `in_known`=1 starts from the known zero state. State 0 has metric 0 and the other states have the most negative signed value. That section's update is then applied.
- R5: A valid section with `in_start`=1 and `in_known`=0 starts from all four metrics equal to 0.
- R6: Cycle k after reset release belongs to sub-block k mod `NSUB`, and `in_sub` must equal that index. Each sub-block's metrics depend only on its own sections.
- R7: In a cycle with `in_valid`=0, that sub-block's stored metrics are left unchanged and `out_valid` stays low.
- R8: A valid section with `in_warm`=1 updates the stored metrics, and its result has `out_valid` low.
- R9: The result of a section captured at clock edge e appears at the outputs after edge e+1. At that point `out_sub` is the section's sub-block index and `out_valid` is high unless the section was a warm-up section.
- R10: While reset is held, `out_valid` is 0, `out_metric` is 0, and every stored sub-block metric is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A trellis section is present this cycle |
| in_sub | input | SUBW | Sub-block index of the section (must match the rotation) |
| in_start | input | 1 | Section is the first of its sub-block |
| in_known | input | 1 | With in_start: begin from the known zero state |
| in_warm | input | 1 | Warm-up section, result not reported |
| in_bm | input | 4*BMW | Branch metrics, one lane per codeword |
| out_valid | output | 1 | Result metrics are valid |
| out_sub | output | SUBW | Sub-block index of the result |
| out_metric | output | 4*SMW | Updated metrics, one signed lane per state |

## Verification
The bench drives the inputs so that the correction table is reached at both ends. Lanes that differ strongly push the candidate difference past 7, and equal lanes produce small differences. Repeated one-sided sections drive the metrics into saturation, which catches a design that wraps or normalizes against the wrong state. One sub-block is left idle for several rotations while the others keep running. A loop that is one stage short or long, or that does not hold idle metrics, then gives that sub-block another sub-block's metrics. Restarts with and without a known state, warm-up rounds, and a lone valid section among idle cycles check the initial values, the suppression of output during warm-up, and the two-edge latency.

// File: rtl/bip_acs_pkg.sv
package bip_acs_pkg;
   localparam int NSTATE = 4;
   localparam int CORRW  = 3;

   // predecessor of next state nxt when its old low bit is x
   function automatic int pred_of(input int nxt, input int x);
      return ((nxt & 1) << 1) | (x & 1);
   endfunction

   // codeword emitted by a branch leaving state p with input bit u
   function automatic int cw_of(input int p, input int u);
      return (((u ^ (p >> 1) ^ p) & 1) << 1) | ((u ^ p) & 1);
   endfunction

   function automatic logic [CORRW-1:0] corr_lut(input logic [2:0] d);
      case (d)
         3'd0:    return 3'd5;
         3'd1:    return 3'd4;
         3'd2:    return 3'd3;
         3'd3:    return 3'd2;
         3'd4:    return 3'd2;
         3'd5:    return 3'd1;
         3'd6:    return 3'd1;
         default: return 3'd0;
      endcase
   endfunction
endpackage

// File: rtl/bip_acs_cmp.sv
// First loop stage: add branch metrics and compare the two candidates per state.
module bip_acs_cmp
   import bip_acs_pkg::*;
#(
   parameter int SMW = 10,
   parameter int BMW = 8
) (
   input  logic [NSTATE*SMW-1:0]     metric_in,
   input  logic [NSTATE*BMW-1:0]     bm,
   input  logic                      upd,
   output logic [NSTATE*(SMW+2)-1:0] mx,
   output logic [NSTATE*3-1:0]       idx
);
   localparam int WW = SMW + 2;

   generate
      for (genvar n = 0; n < NSTATE; n++) begin : g_st
         localparam int P0 = pred_of(n, 0);
         localparam int P1 = pred_of(n, 1);
         localparam int U  = n >> 1;
         localparam int C0 = cw_of(P0, U);
         localparam int C1 = cw_of(P1, U);
         logic signed [WW-1:0] cand_a, cand_b, diff, mag, own, best;
         logic [2:0]           dsat;

         always_comb begin
            cand_a = {{2{metric_in[P0*SMW+SMW-1]}}, metric_in[P0*SMW +: SMW]}
                   + {{(WW-BMW){1'b0}}, bm[C0*BMW +: BMW]};
            cand_b = {{2{metric_in[P1*SMW+SMW-1]}}, metric_in[P1*SMW +: SMW]}
                   + {{(WW-BMW){1'b0}}, bm[C1*BMW +: BMW]};
            own    = {{2{metric_in[n*SMW+SMW-1]}}, metric_in[n*SMW +: SMW]};
            diff   = cand_a - cand_b;
            mag    = diff[WW-1] ? -diff : diff;
            if (!upd) begin
               best = own;
               dsat = 3'd7;
            end else begin
               best = diff[WW-1] ? cand_b : cand_a;
               dsat = (mag > 7) ? 3'd7 : mag[2:0];
            end
         end

         assign mx[n*WW +: WW] = best;
         assign idx[n*3 +: 3]  = dsat;
      end
   endgenerate
endmodule

// File: rtl/bip_acs_norm.sv
// Second loop stage: correction, normalization against state 0, saturation.
module bip_acs_norm
   import bip_acs_pkg::*;
#(
   parameter int SMW = 10
) (
   input  logic [NSTATE*(SMW+2)-1:0] mx,
   input  logic [NSTATE*3-1:0]       idx,
   output logic [NSTATE*SMW-1:0]     metric_out
);
   localparam int WW   = SMW + 2;
   localparam int MAXV = 2**(SMW-1) - 1;
   localparam int MINV = -(2**(SMW-1));
   localparam logic [SMW-1:0] SAT_HI = {1'b0, {(SMW-1){1'b1}}};
   localparam logic [SMW-1:0] SAT_LO = {1'b1, {(SMW-1){1'b0}}};

   logic signed [WW-1:0] corr_v [NSTATE];

   generate
      for (genvar n = 0; n < NSTATE; n++) begin : g_st
         logic signed [WW-1:0] rel;
         assign corr_v[n] = mx[n*WW +: WW] + {{(WW-CORRW){1'b0}}, corr_lut(idx[n*3 +: 3])};
         assign rel       = corr_v[n] - corr_v[0];
         always_comb begin
            if (rel > MAXV)      metric_out[n*SMW +: SMW] = SAT_HI;
            else if (rel < MINV) metric_out[n*SMW +: SMW] = SAT_LO;
            else                 metric_out[n*SMW +: SMW] = rel[SMW-1:0];
         end
      end
   endgenerate
endmodule

// File: rtl/bip_acs_delay.sv
// Plain register delay line closing the recursion loop.
module bip_acs_delay #(
   parameter int W     = 40,
   parameter int DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] sr [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) sr[i] <= '0;
      end else begin
         sr[0] <= d;
         for (int i = 1; i < DEPTH; i++) sr[i] <= sr[i-1];
      end
   end

   assign q = sr[DEPTH-1];
endmodule

// File: rtl/bip_acs_fwd.sv
module bip_acs_fwd
   import bip_acs_pkg::*;
#(
   parameter int NSUB = 4,
   parameter int SMW  = 10,
   parameter int BMW  = 8,
   localparam int SUBW = (NSUB > 1) ? $clog2(NSUB) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   input  logic [SUBW-1:0]       in_sub,
   input  logic                  in_start,
   input  logic                  in_known,
   input  logic                  in_warm,
   input  logic [NSTATE*BMW-1:0] in_bm,
   output logic                  out_valid,
   output logic [SUBW-1:0]       out_sub,
   output logic [NSTATE*SMW-1:0] out_metric
);
   localparam int WW  = SMW + 2;
   localparam int DLY = NSUB - 2;
   localparam int MW  = NSTATE * SMW;
   localparam logic [SMW-1:0] NEG_MOST = {1'b1, {(SMW-1){1'b0}}};

   generate
      if (NSUB < 2) begin : g_bad_nsub
         $error("bip_acs_fwd: NSUB must be at least 2 to fill the two ACS stages");
      end
      if (BMW >= WW) begin : g_bad_bmw
         $error("bip_acs_fwd: BMW must be narrower than SMW+2");
      end
      if (SMW < 4) begin : g_bad_smw
         $error("bip_acs_fwd: SMW too small for the correction range");
      end
   endgenerate

   // rotation slot owned by the current cycle
   logic [SUBW-1:0] slot_q;
   always_ff @(posedge clk) begin
      if (!rst_n)                          slot_q <= '0;
      else if (slot_q == SUBW'(NSUB - 1))  slot_q <= '0;
      else                                 slot_q <= slot_q + 1'b1;
   end

   logic [MW-1:0] ring_tail, init_vec, base_vec;
   assign init_vec = in_known ? {{(NSTATE-1){NEG_MOST}}, {SMW{1'b0}}} : '0;
   assign base_vec = (in_valid && in_start) ? init_vec : ring_tail;

   // stage 1
   logic [NSTATE*WW-1:0] cmp_mx, s1_mx;
   logic [NSTATE*3-1:0]  cmp_idx, s1_idx;
   logic                 s1_vld;
   logic [SUBW-1:0]      s1_sub;

   bip_acs_cmp #(.SMW(SMW), .BMW(BMW)) u_cmp (
      .metric_in (base_vec),
      .bm        (in_bm),
      .upd       (in_valid),
      .mx        (cmp_mx),
      .idx       (cmp_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_mx  <= '0;
         s1_idx <= '1;
         s1_vld <= 1'b0;
         s1_sub <= '0;
      end else begin
         s1_mx  <= cmp_mx;
         s1_idx <= cmp_idx;
         s1_vld <= in_valid && !in_warm;
         s1_sub <= in_sub;
      end
   end

   // stage 2
   logic [MW-1:0]   nrm_m, s2_m;
   logic            s2_vld;
   logic [SUBW-1:0] s2_sub;

   bip_acs_norm #(.SMW(SMW)) u_norm (
      .mx         (s1_mx),
      .idx        (s1_idx),
      .metric_out (nrm_m)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s2_m   <= '0;
         s2_vld <= 1'b0;
         s2_sub <= '0;
      end else begin
         s2_m   <= nrm_m;
         s2_vld <= s1_vld;
         s2_sub <= s1_sub;
      end
   end

   // remaining loop stages
   generate
      if (DLY == 0) begin : g_loop_short
         assign ring_tail = s2_m;
      end else begin : g_loop_long
         bip_acs_delay #(.W(MW), .DEPTH(DLY)) u_dly (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (s2_m),
            .q     (ring_tail)
         );
      end
   endgenerate

   assign out_valid  = s2_vld;
   assign out_sub    = s2_sub;
   assign out_metric = s2_m;

   // R6: sections must arrive in their rotation slot
   p_tag_rotation_r6: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> (in_sub == slot_q));

   // R7: idle slot reports nothing two edges later
   p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |-> ##2 !out_valid);

   // R8: warm-up sections are never reported
   p_warm_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_warm) |-> ##2 !out_valid);

   // R9: reported sections appear after the following edge with their tag
   p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_warm) |-> ##2 (out_valid && out_sub == $past(in_sub, 2)));
endmodule

// File: tb/tb_bip_acs_fwd.sv
module tb_bip_acs_fwd;
   localparam int NSUB = 4;
   localparam int SMW  = 10;
   localparam int BMW  = 8;
   localparam int SUBW = 2;
   localparam int MAXV = 511;
   localparam int MINV = -512;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic            rst_n;
   logic            in_valid, in_start, in_known, in_warm;
   logic [SUBW-1:0] in_sub;
   logic [4*BMW-1:0] in_bm;
   logic            out_valid;
   logic [SUBW-1:0] out_sub;
   logic [4*SMW-1:0] out_metric;

   bip_acs_fwd #(.NSUB(NSUB), .SMW(SMW), .BMW(BMW)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sub(in_sub),
      .in_start(in_start), .in_known(in_known), .in_warm(in_warm), .in_bm(in_bm),
      .out_valid(out_valid), .out_sub(out_sub), .out_metric(out_metric)
   );

   typedef struct {
      bit               v;
      int               sub;
      logic [4*SMW-1:0] m;
      string            tag;
   } exp_t;

   exp_t        q[$];
   int          model [NSUB][4];
   int          checks = 0;
   int          fails = 0;
   int          cyc = 0;
   int unsigned seed = 32'h2468ace1;

   function automatic int unsigned rnd();
      seed = seed * 32'd1103515245 + 32'd12345;
      return (seed >> 16) & 32'hff;
   endfunction

   function automatic int corr(input int d);
      case (d)
         0: return 5;  1: return 4;  2: return 3;  3: return 2;
         4: return 2;  5: return 1;  6: return 1;  default: return 0;
      endcase
   endfunction

   function automatic int sat(input int x);
      if (x > MAXV) return MAXV;
      if (x < MINV) return MINV;
      return x;
   endfunction

   task automatic check_one(input exp_t e);
      checks++;
      if (out_valid !== e.v || (e.v && (out_sub !== e.sub[SUBW-1:0] || out_metric !== e.m))) begin
         fails++;
         $display("FAIL %s: valid/sub/metrics got %b/%0d/%h expected %b/%0d/%h",
                  e.tag, out_valid, out_sub, out_metric, e.v, e.sub, e.m);
      end
   endtask

   // one cycle: compare the result due now, drive a section, predict its result
   task automatic step(input bit v, input bit st, input bit kn, input bit wm,
                       input int b0, input int b1, input int b2, input int b3,
                       input string tag);
      exp_t e;
      int   sub, bmv[4], base[4], vv[4], rr[4];
      if (q.size() >= 2) check_one(q.pop_front());
      sub = cyc % NSUB;
      bmv[0] = b0 & 255; bmv[1] = b1 & 255; bmv[2] = b2 & 255; bmv[3] = b3 & 255;
      in_valid = v; in_start = st; in_known = kn; in_warm = wm;
      in_sub   = sub[SUBW-1:0];
      in_bm    = {bmv[3][7:0], bmv[2][7:0], bmv[1][7:0], bmv[0][7:0]};
      e.v = v && !wm; e.sub = sub; e.tag = tag; e.m = '0;
      if (v) begin
         for (int s = 0; s < 4; s++)
            base[s] = !st ? model[sub][s] : (kn ? (s == 0 ? 0 : MINV) : 0);
         for (int n = 0; n < 4; n++) begin
            int u, ca, cb, best, d;
            u = n >> 1;
            ca = 0; cb = 0;
            for (int x = 0; x < 2; x++) begin
               int p, c;
               p = ((n & 1) << 1) | x;
               c = (((u ^ (p >> 1) ^ p) & 1) << 1) | ((u ^ p) & 1);
               if (x == 0) ca = base[p] + bmv[c];
               else        cb = base[p] + bmv[c];
            end
            best = (ca >= cb) ? ca : cb;
            d = (ca >= cb) ? ca - cb : cb - ca;
            vv[n] = best + corr(d > 7 ? 7 : d);
         end
         for (int n = 0; n < 4; n++) begin
            rr[n] = sat(vv[n] - vv[0]);
            model[sub][n] = rr[n];
            e.m[n*SMW +: SMW] = rr[n][SMW-1:0];
         end
      end
      q.push_back(e);
      cyc++;
      @(negedge clk);
   endtask

   task automatic rstep(input bit v, input bit st, input bit kn, input bit wm, input string tag);
      int r0, r1, r2, r3;
      r0 = int'(rnd()); r1 = int'(rnd()); r2 = int'(rnd()); r3 = int'(rnd());
      step(v, st, kn, wm, r0, r1, r2, r3, tag);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin : main
      for (int s = 0; s < NSUB; s++)
         for (int n = 0; n < 4; n++) model[s][n] = 0;
      rst_n = 1'b0; in_valid = 0; in_start = 0; in_known = 0; in_warm = 0;
      in_sub = '0; in_bm = '0;
      repeat (3) @(negedge clk);
      // R10: reset state of the outputs
      checks++;
      if (out_valid !== 1'b0 || out_metric !== '0) begin
         fails++;
         $display("FAIL R10: valid/metrics got %b/%h expected 0/0", out_valid, out_metric);
      end
      rst_n = 1'b1;

      // R10: first round runs from the zeroed stored metrics
      for (int i = 0; i < NSUB; i++) rstep(1, 0, 0, 0, "R10");
      // R1: trellis connectivity, one hot lane per round
      for (int c = 0; c < 4; c++)
         for (int i = 0; i < NSUB; i++)
            step(1, 0, 0, 0, c == 0 ? 90 : 0, c == 1 ? 90 : 0, c == 2 ? 90 : 0, c == 3 ? 90 : 0, "R1");
      // R4: known-state start on every sub-block
      for (int i = 0; i < NSUB; i++) rstep(1, 1, 1, 0, "R4");
      // R2: general sections, then equal lanes for small differences
      for (int i = 0; i < 16; i++) rstep(1, 0, 0, 0, "R2");
      for (int i = 0; i < 8; i++) step(1, 0, 0, 0, 100, 100, 100, 100, "R2");
      for (int i = 0; i < 8; i++) step(1, 0, 0, 0, 3, 0, 1, 2, "R2");
      // R3: strongly one-sided sections force saturation
      for (int i = 0; i < 16; i++) step(1, 0, 0, 0, 255, 0, 0, 255, "R3");
      for (int i = 0; i < 16; i++) step(1, 0, 0, 0, 0, 255, 255, 0, "R3");
      // R7: sub-block 2 idles for six rounds, then resumes
      for (int i = 0; i < 6 * NSUB; i++) rstep((cyc % NSUB) != 2, 0, 0, 0, "R7");
      for (int i = 0; i < NSUB; i++) rstep(1, 0, 0, 0, "R7");
      // R5 and R8: sub-block 1 restarts unknown and warms up for three rounds
      for (int r = 0; r < 3; r++)
         for (int i = 0; i < NSUB; i++) begin
            bit w;
            w = (cyc % NSUB) == 1;
            rstep(1, w && r == 0, 0, w, w ? "R8" : "R5");
         end
      for (int i = 0; i < 3 * NSUB; i++) rstep(1, 0, 0, 0, "R5");
      // R6: sub-block 0 restarts while the others keep going
      for (int i = 0; i < NSUB; i++) rstep(1, (cyc % NSUB) == 0, 1, 0, "R6");
      for (int i = 0; i < 3 * NSUB; i++) rstep(1, 0, 0, 0, "R6");
      // R9: a lone section among idle cycles
      for (int i = 0; i < 2 * NSUB; i++) rstep((cyc % NSUB) == 3, 0, 0, 0, "R9");
      for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 0, 0, 0, "R9");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule